// File: doc/BRIEF.md
# SPI Serial Clock and Frame Timing Controller

This block sets the timing of an SPI host. A counter that reloads from a programmable divisor produces a one-cycle enable pulse, the tick, at twice the serial clock rate. The tick drives every timed event in the block. During a frame, each tick toggles the serial clock, which gives one SCLK edge per tick. The 2-bit clock mode sets the SCLK idle level. It also decides which edges carry the shift strobe and which carry the sample strobe.

A frame is a programmable number of bits, and the block wraps each frame in chip-select timing:
- a lead time from chip-select assertion to the first clock edge;
- a trail time from the last edge to chip-select release;
- a minimum idle gap with chip select released.

When the transmit queue still holds data at the end of a frame, another frame follows. In auto chip-select mode the next frame goes through the full release/gap/lead cycle. In hold mode chip select stays asserted, and the next frame follows either at once or after a programmable inter-frame gap. The register interface and the data shift registers lie outside this block. They are driven by the strobes this block puts out.

All delays are counted in ticks, which are half SCLK periods. A delay value of 0 counts as 1, except for the inter-frame gap, where 0 means no gap.

Top module: `spi_frame_timer`

## Requirements
- R1: `tick_o` pulses once every divisor+1 clock cycles, so one full SCLK period during a frame is 2*(divisor+1) cycles.
- R2: A cycle with `div_wr_i` high restarts the tick counter. The next tick then occurs exactly divisor+1 cycles after that write cycle.
- R3: A frame of length code n gives n shift strobes, n sample strobes and 2n SCLK transitions. The length code 0 means 16 bits, and `shift_o` and `sample_o` are never high together.
- R4: `mode_i[1]` is the SCLK idle level. `mode_i[0]` is the phase. With phase 0 the first strobe of a frame is a sample strobe; with phase 1 it is a shift strobe. Every sample strobe occurs while SCLK is at level `mode_i[1]` XOR `mode_i[0]`, just before the edge it marks.
- R5: After `inactive_o` falls, max(lead,1) ticks pass before the tick that carries the first strobe of the frame.
- R6: A single frame keeps `busy_o` high for L+2n+1+T+G ticks. Here L, T and G are max(value,1) of the lead, trail and chip-select gap settings.
- R7: Each frame gives exactly one `eof_o` pulse, on the tick of its last SCLK edge. It also gives exactly one `eof_d_o` pulse, on the following tick.
- R8: In hold mode (`cs_hold_i`=1), when `tx_empty_i` is low at `eof_d_o`, the next frame starts with `inactive_o` still low. It starts either on the next tick or after F ticks when the inter-frame gap F is nonzero. k frames take L+k(2n+1)+(k-1)F+T+G ticks.
- R9: In auto mode (`cs_hold_i`=0), every frame is followed by trail and gap. `inactive_o` is high for G ticks after each frame, and k frames take k(L+2n+1+T+G) ticks.
- R10: After reset and whenever idle: `busy_o`=0, `inactive_o`=1, SCLK rests at `mode_i[1]`, and neither strobe is produced.
- R11: A `start_i` pulse while `busy_o` is high is ignored. The block returns to idle once the data runs out and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Clock divisor |
| div_wr_i | input | 1 | Divisor write strobe, restarts the tick counter |
| mode_i | input | 2 | Bit 1 polarity, bit 0 phase |
| cs_hold_i | input | 1 | 1: keep chip select asserted between frames |
| lead_i | input | DLY_W | Chip-select-to-first-edge delay in ticks |
| trail_i | input | DLY_W | Last-edge-to-chip-select-release delay in ticks |
| csgap_i | input | DLY_W | Minimum chip-select idle time in ticks |
| fgap_i | input | DLY_W | Inter-frame gap in hold mode, in ticks |
| len_i | input | LEN_W | Bits per frame, 0 means 2**LEN_W |
| start_i | input | 1 | Start request pulse |
| tx_empty_i | input | 1 | Transmit queue empty |
| sclk_o | output | 1 | Serial clock |
| tick_o | output | 1 | Half-period enable pulse |
| shift_o | output | 1 | Shift strobe |
| sample_o | output | 1 | Sample strobe |
| eof_o | output | 1 | End-of-frame strobe |
| eof_d_o | output | 1 | End-of-frame strobe delayed by one tick |
| busy_o | output | 1 | Transmitting flag |
| inactive_o | output | 1 | Chip select at default level |

## Verification
The frame path is swept over five length codes, including 1 and the 0 code for 16 bits, all four clock modes and two divisors. Strobe counts, edge counts and the kind and SCLK level of the first strobe separate the length decode from the polarity and phase handling. Lead, trail and gap settings, including zeros, are varied on their own, so that each setting shows up only in its own tick count. Multi-frame runs in hold mode, with and without an inter-frame gap, are set against runs in auto mode to tell held chip select from released chip select. Separate runs cover the divisor restart and a start request issued while a frame is in progress.

// File: rtl/spi_timing_pkg.sv
package spi_timing_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_FEND,
      ST_FGAP,
      ST_TRAIL,
      ST_CSGAP
   } seq_state_e;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
   parameter int DIV_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   input  logic             restart_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   // >= keeps the period sane when the divisor is lowered mid-count
   assign tick_o = (cnt_q >= div_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (restart_i || tick_o) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
   end

   p_tick_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (restart_i && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq import spi_timing_pkg::*; #(
   parameter int DLY_W = 8,
   parameter int LEN_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             tx_empty_i,
   input  logic             hold_i,
   input  logic [DLY_W-1:0] lead_i,
   input  logic [DLY_W-1:0] trail_i,
   input  logic [DLY_W-1:0] csgap_i,
   input  logic [DLY_W-1:0] fgap_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             shifting_o,
   output logic             edge_odd_o,
   output logic             eof_o,
   output logic             eof_d_o,
   output logic             busy_o,
   output logic             inactive_o
);

   localparam int CNT_W = (DLY_W > LEN_W + 2) ? DLY_W : LEN_W + 2;

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_last;
   logic [LEN_W:0]   nbits;
   logic             pend_q, done;

   function automatic logic [CNT_W-1:0] last_of(input logic [DLY_W-1:0] d);
      return (d == '0) ? '0 : CNT_W'(d) - CNT_W'(1);
   endfunction

   assign nbits = (len_i == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_i};

   always_comb begin
      case (state_q)
         ST_LEAD:  cnt_last = last_of(lead_i);
         ST_SHIFT: cnt_last = CNT_W'({nbits, 1'b0}) - CNT_W'(1);
         ST_FGAP:  cnt_last = last_of(fgap_i);
         ST_TRAIL: cnt_last = last_of(trail_i);
         ST_CSGAP: cnt_last = last_of(csgap_i);
         default:  cnt_last = '0;
      endcase
   end

   assign done = (cnt_q == cnt_last);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (pend_q || start_i) state_d = ST_LEAD;
         ST_LEAD:  if (done) state_d = ST_SHIFT;
         ST_SHIFT: if (done) state_d = ST_FEND;
         ST_FEND: begin
            if (!tx_empty_i && hold_i)
               state_d = (fgap_i != '0) ? ST_FGAP : ST_SHIFT;
            else
               state_d = ST_TRAIL;
         end
         ST_FGAP:  if (done) state_d = ST_SHIFT;
         ST_TRAIL: if (done) state_d = ST_CSGAP;
         ST_CSGAP: if (done) state_d = tx_empty_i ? ST_IDLE : ST_LEAD;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (tick_i) begin
         state_q <= state_d;
         cnt_q   <= (state_d != state_q || state_q == ST_IDLE) ? '0 : cnt_q + 1'b1;
      end
   end

   // a request is only taken while idle; one arriving mid-run is dropped
   always_ff @(posedge clk_i) begin
      if (!rst_ni)                  pend_q <= 1'b0;
      else if (state_q != ST_IDLE)  pend_q <= 1'b0;
      else if (tick_i)              pend_q <= 1'b0;
      else if (start_i)             pend_q <= 1'b1;
   end

   assign shifting_o = tick_i && (state_q == ST_SHIFT);
   assign edge_odd_o = cnt_q[0];
   assign eof_o      = shifting_o && done;
   assign eof_d_o    = tick_i && (state_q == ST_FEND);
   assign busy_o     = (state_q != ST_IDLE);
   assign inactive_o = (state_q == ST_IDLE) || (state_q == ST_CSGAP);

   p_eof_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eof_o |=> !eof_o);
   p_eofd_outside_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eof_d_o |-> (busy_o && !shifting_o));
   p_inactive_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inactive_o |-> !shifting_o);

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer #(
   parameter int DIV_W = 12,
   parameter int DLY_W = 8,
   parameter int LEN_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   input  logic             div_wr_i,
   input  logic [1:0]       mode_i,
   input  logic             cs_hold_i,
   input  logic [DLY_W-1:0] lead_i,
   input  logic [DLY_W-1:0] trail_i,
   input  logic [DLY_W-1:0] csgap_i,
   input  logic [DLY_W-1:0] fgap_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             start_i,
   input  logic             tx_empty_i,
   output logic             sclk_o,
   output logic             tick_o,
   output logic             shift_o,
   output logic             sample_o,
   output logic             eof_o,
   output logic             eof_d_o,
   output logic             busy_o,
   output logic             inactive_o
);

   initial begin
      assert (DIV_W >= 2) else $error("DIV_W too small");
      assert (DLY_W >= 1) else $error("DLY_W too small");
      assert (LEN_W >= 1 && LEN_W <= 8) else $error("LEN_W out of range");
   end

   logic tick, shifting, edge_odd, sck_lvl_q, shift_slot;

   spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .div_i     (div_i),
      .restart_i (div_wr_i),
      .tick_o    (tick)
   );

   spi_frame_seq #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .start_i    (start_i),
      .tx_empty_i (tx_empty_i),
      .hold_i     (cs_hold_i),
      .lead_i     (lead_i),
      .trail_i    (trail_i),
      .csgap_i    (csgap_i),
      .fgap_i     (fgap_i),
      .len_i      (len_i),
      .shifting_o (shifting),
      .edge_odd_o (edge_odd),
      .eof_o      (eof_o),
      .eof_d_o    (eof_d_o),
      .busy_o     (busy_o),
      .inactive_o (inactive_o)
   );

   // even-numbered edges are leading; phase 0 shifts on trailing edges
   always_ff @(posedge clk_i) begin
      if (!rst_ni)       sck_lvl_q <= 1'b0;
      else if (shifting) sck_lvl_q <= ~sck_lvl_q;
   end

   assign shift_slot = edge_odd ^ mode_i[0];
   assign shift_o    = shifting && shift_slot;
   assign sample_o   = shifting && !shift_slot;
   assign sclk_o     = mode_i[1] ^ sck_lvl_q;
   assign tick_o     = tick;

   p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (sclk_o == mode_i[1]));
   p_sclk_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_o && $stable(mode_i)) |=> $stable(sclk_o));
   p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(shift_o && sample_o));
   p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (!shift_o && !sample_o));

endmodule

// File: tb/tb_spi_frame_timer.sv
`timescale 1ns/1ps
module tb_spi_frame_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] div = 12'd3;
   logic        div_wr = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        hold = 1'b0;
   logic [7:0]  lead = 8'd1, trail = 8'd1, csgap = 8'd1, fgap = 8'd0;
   logic [3:0]  len = 4'd8;
   logic        start = 1'b0;
   logic        tx_empty = 1'b1;
   logic        sclk, tick, shift, sample, eof, eof_d, busy, inactive;

   always #10 clk = ~clk;

   spi_frame_timer dut (
      .clk_i(clk), .rst_ni(rst_n), .div_i(div), .div_wr_i(div_wr),
      .mode_i(mode), .cs_hold_i(hold), .lead_i(lead), .trail_i(trail),
      .csgap_i(csgap), .fgap_i(fgap), .len_i(len), .start_i(start),
      .tx_empty_i(tx_empty), .sclk_o(sclk), .tick_o(tick), .shift_o(shift),
      .sample_o(sample), .eof_o(eof), .eof_d_o(eof_d), .busy_o(busy),
      .inactive_o(inactive)
   );

   int n_chk = 0, n_fail = 0, cycles = 0;
   int n_ticks, n_shift, n_sample, n_idle_strb, n_badlvl, n_lead, n_gap;
   int n_tog, n_eof, n_eofd, want = 0;
   bit seen, first_shift, sclk_prev;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (tick && busy) n_ticks++;
      if (shift) n_shift++;
      if (sample) n_sample++;
      if ((shift || sample) && !busy) n_idle_strb++;
      if (sample && sclk != (mode[1] ^ mode[0])) n_badlvl++;
      if (!seen && tick && busy && !inactive && !shift && !sample) n_lead++;
      if (!seen && (shift || sample)) begin seen = 1; first_shift = shift; end
      if (tick && busy && inactive) n_gap++;
      if (sclk != sclk_prev) n_tog++;
      if (eof) n_eof++;
      if (eof_d) n_eofd++;
      sclk_prev = sclk;
      tx_empty = (n_eofd >= want);
   end

   function automatic int mx1(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   // one run of k frames; counters cleared away from the sampling edge
   task automatic run(input int k, input bit extra_start, input string tag);
      int n, nb, L, T, G, F, exp_t;
      repeat (3) @(negedge clk);
      @(posedge clk); #1;
      n_ticks = 0; n_shift = 0; n_sample = 0; n_idle_strb = 0; n_badlvl = 0;
      n_lead = 0; n_gap = 0; n_tog = 0; n_eof = 0; n_eofd = 0; seen = 0;
      want = k;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!busy) @(negedge clk);
      if (extra_start) begin
         repeat (3) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;
      end
      while (busy) @(negedge clk);
      nb = (len == 0) ? 16 : int'(len);
      L = mx1(lead); T = mx1(trail); G = mx1(csgap); F = int'(fgap);
      if (hold) exp_t = L + k * (2 * nb + 1) + (k - 1) * F + T + G;
      else      exp_t = k * (L + 2 * nb + 1 + T + G);
      chk({"R6 R8 R9 busy ticks ", tag}, n_ticks, exp_t);
      chk({"R3 shift count ", tag}, n_shift, k * nb);
      chk({"R3 sample count ", tag}, n_sample, k * nb);
      chk({"R3 sclk edges ", tag}, n_tog, 2 * k * nb);
      chk({"R4 first strobe is shift ", tag}, int'(first_shift), int'(mode[0]));
      chk({"R4 sample level ", tag}, n_badlvl, 0);
      chk({"R5 lead ticks ", tag}, n_lead, L);
      chk({"R9 R8 released gap ticks ", tag}, n_gap, hold ? G : k * G);
      chk({"R7 eof count ", tag}, n_eof, k);
      chk({"R7 delayed eof count ", tag}, n_eofd, k);
      chk({"R10 idle strobes ", tag}, n_idle_strb, 0);
      chk({"R10 sclk idle level ", tag}, int'(sclk), int'(mode[1]));
      if (extra_start) begin
         n = 0;
         repeat (4 * (int'(div) + 1) + 6) begin
            @(negedge clk);
            if (busy) n++;
         end
         chk({"R11 restart after extra start ", tag}, n, 0);
      end
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset busy", int'(busy), 0);
      chk("R10 reset inactive", int'(inactive), 1);
      chk("R10 reset sclk", int'(sclk), 0);
      chk("R10 reset strobes", int'(shift | sample), 0);
      rst_n = 1'b1;

      // R1 tick period
      foreach (n_per[i]) begin
         div = 12'(n_per[i]);
         @(negedge clk);
         while (!tick) @(negedge clk);
         @(negedge clk);
         n = 1;
         while (!tick) begin n++; @(negedge clk); end
         chk("R1 tick period", n, n_per[i] + 1);
      end

      // R2 restart on divisor write
      div = 12'd5;
      while (!tick) @(negedge clk);
      repeat (2) @(negedge clk);
      div_wr = 1'b1;
      @(negedge clk);
      div_wr = 1'b0;
      n = 0;
      while (!tick) begin n++; @(negedge clk); end
      chk("R2 restart to tick", n, 5);

      // R3 R4 sweep: length x mode x divisor
      for (int d = 0; d < 2; d++)
         for (int m = 0; m < 4; m++)
            foreach (lens[i]) begin
               div = 12'(d * 2); mode = 2'(m); len = 4'(lens[i]);
               run(1, 1'b0, $sformatf("d%0d m%0d l%0d", d * 2, m, lens[i]));
            end

      // R5 R6 delay settings, zero values included
      div = 12'd1; mode = 2'b01; len = 4'd3;
      lead = 8'd0; trail = 8'd2; csgap = 8'd3; run(1, 1'b0, "dly A");
      lead = 8'd4; trail = 8'd0; csgap = 8'd1; run(1, 1'b0, "dly B");
      lead = 8'd2; trail = 8'd5; csgap = 8'd0; run(1, 1'b0, "dly C");

      // R8 hold mode, R9 auto mode, R11 start during a run
      lead = 8'd2; trail = 8'd1; csgap = 8'd2; mode = 2'b10; len = 4'd4;
      hold = 1'b1; fgap = 8'd0; run(3, 1'b0, "hold nogap");
      hold = 1'b1; fgap = 8'd3; run(2, 1'b0, "hold gap3");
      hold = 1'b0; fgap = 8'd3; run(3, 1'b0, "auto");
      hold = 1'b0; fgap = 8'd0; run(1, 1'b1, "extra start");

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   int n_per[4] = '{0, 1, 3, 6};
   int lens[5]  = '{1, 2, 5, 8, 0};

endmodule